// File: doc/BRIEF.md
# External Bus Request Arbiter

This block decides when a processor hands its external memory bus to another master. An outside device pulls an active-low request line. The block brings that line into the processor clock domain, waits for any external access already under way to finish, and then answers in three ways: it asserts an active-low grant, turns off the drivers on the address, data and strobe pins, and halts the instruction sequencer. When the request line goes inactive again, the grant is withdrawn, the drivers come back on and the processor continues from the instruction where it stopped.

With the run-on mode enabled, the processor keeps executing after the bus is granted. It stops only when the core reports that it needs an external access. An active-low hung output tells the bus owner that the processor is granted out and is waiting on a stalled access, so the owner can give the bus back. Request handling continues while reset is asserted, so a device can own the bus during boot.

Top module: `bus_grant_arb`

## Requirements
- R1: `bus_req_n` passes through two clock stages before it is used. With no access in progress, `bus_grant_n` goes low at the third rising edge after `bus_req_n` falls.
- R2: `bus_drv_en` is low in exactly the cycles in which `bus_grant_n` is low.
- R3: With `go_mode_en` low, `core_halt` goes high at the same edge at which the grant is asserted, and stays high while the grant is held.
- R4: With `go_mode_en` high, `core_halt` stays low while the bus is granted and `core_acc_pend` is low. It goes high at the first edge that samples `core_acc_pend` high.
- R5: While `core_acc_busy` is high and `core_acc_done` is low, a synchronized request is not granted. The grant is asserted at the edge that samples `core_acc_done` high, which is the cycle after the access completes.
- R6: If one access completes (`core_acc_busy` and `core_acc_done` both high) and a second access is about to follow, the grant is given at that completion, between the two accesses.
- R7: At the third rising edge after `bus_req_n` rises, `bus_grant_n` and `bus_hung_n` both go high, `bus_drv_en` goes high and `core_halt` goes low, all at the same edge.
- R8: `bus_hung_n` is low exactly when the grant is held and `core_acc_pend` was high at the previous edge.
- R9: While `rst_n` is low, the grant follows the synchronized request. `core_halt` stays low and `bus_hung_n` stays high, and the access inputs are ignored. After reset with no request active, `bus_grant_n` = 1, `bus_drv_en` = 1, `core_halt` = 0 and `bus_hung_n` = 1.
- R10: Once the grant is held, `core_acc_busy` and `core_acc_done` have no effect on it until the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset for the core side |
| bus_req_n | input | 1 | Asynchronous bus request from another master, active low |
| go_mode_en | input | 1 | Keeps execution running while the bus is granted |
| core_acc_pend | input | 1 | The core needs an external memory or DMA access |
| core_acc_busy | input | 1 | An external access is in progress |
| core_acc_done | input | 1 | The access in progress completes in this cycle |
| bus_grant_n | output | 1 | Bus grant, active low |
| bus_hung_n | output | 1 | Granted and stalled on a pending access, active low |
| bus_drv_en | output | 1 | Enable for the address, data and strobe output drivers |
| core_halt | output | 1 | Stall request to the instruction sequencer |

## Verification
A change on the request line appears at the outputs at the third rising edge: two synchronizer stages, then the output registers. Every core-side input appears at the outputs at the next edge. The bench drives inputs on falling edges and samples on falling edges. Each directed check counts edges from the stimulus and samples both the last cycle before the expected change and the first cycle after it. The vector table holds each input pattern for more cycles than the longest latency before it checks the settled outputs.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    typedef enum logic [1:0] {
        ARB_OWN     = 2'd0,
        ARB_DEFER   = 2'd1,
        ARB_GRANTED = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       grant;
        logic       drv_en;
        logic       halt;
        logic       hung;
    } arb_regs_t;

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic level
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sh_q;
    logic [LAST:0] sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = ~async_n;
        end else begin : g_chain
            always_comb sh_d = {sh_q[LAST-1:0], ~async_n};
        end
    endgenerate

    // No reset: the request path must work while reset is held.
    always_ff @(posedge clk) begin
        sh_q <= sh_d;
    end

    assign level = sh_q[LAST];
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
    import busarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic go_en,
    input  logic acc_pend,
    input  logic acc_busy,
    input  logic acc_done,
    output logic grant,
    output logic drv_en,
    output logic halt,
    output logic hung
);
    arb_regs_t r_d;
    arb_regs_t r_q;
    logic      handover_ok;

    always_comb begin
        r_d         = r_q;
        handover_ok = acc_busy ? acc_done : 1'b1;
        case (r_q.st)
            ARB_OWN: begin
                if (req_s) r_d.st = handover_ok ? ARB_GRANTED : ARB_DEFER;
            end
            ARB_DEFER: begin
                if (!req_s)          r_d.st = ARB_OWN;
                else if (handover_ok) r_d.st = ARB_GRANTED;
            end
            ARB_GRANTED: begin
                if (!req_s) r_d.st = ARB_OWN;
            end
            default: r_d.st = ARB_OWN;
        endcase
        if (!rst_n) begin
            r_d.st = req_s ? ARB_GRANTED : ARB_OWN;
        end
        r_d.grant  = (r_d.st == ARB_GRANTED);
        r_d.drv_en = !r_d.grant;
        r_d.halt   = rst_n && r_d.grant && (!go_en || acc_pend);
        r_d.hung   = rst_n && r_d.grant && acc_pend;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign grant  = r_q.grant;
    assign drv_en = r_q.drv_en;
    assign halt   = r_q.halt;
    assign hung   = r_q.hung;

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(req_s)); // R1
    AST_DEFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && req_s && acc_busy && !acc_done) |=> !grant); // R5
    AST_HALT_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant) && $past(rst_n) && !$past(go_en)) |-> halt); // R3
    AST_GO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(rst_n) && $past(go_en) && !$past(acc_pend)) |-> !halt); // R4
    AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !req_s) |=> (!grant && !hung && !halt)); // R7
    AST_HUNG_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        hung |-> grant); // R8
    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_s) |=> grant); // R10
endmodule

// File: rtl/bus_grant_arb.sv
module bus_grant_arb #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_n,
    input  logic go_mode_en,
    input  logic core_acc_pend,
    input  logic core_acc_busy,
    input  logic core_acc_done,
    output logic bus_grant_n,
    output logic bus_hung_n,
    output logic bus_drv_en,
    output logic core_halt
);
    logic req_s;
    logic grant;
    logic hung;

    busarb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .async_n (bus_req_n),
        .level   (req_s)
    );

    busarb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (req_s),
        .go_en    (go_mode_en),
        .acc_pend (core_acc_pend),
        .acc_busy (core_acc_busy),
        .acc_done (core_acc_done),
        .grant    (grant),
        .drv_en   (bus_drv_en),
        .halt     (core_halt),
        .hung     (hung)
    );

    assign bus_grant_n = ~grant;
    assign bus_hung_n  = ~hung;

    AST_DRV_OFF_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv_en == bus_grant_n); // R2
endmodule

// File: tb/bus_grant_arb_test.sv
module bus_grant_arb_test;
    logic clk = 1'b0;
    logic rst_n, bus_req_n, go_mode_en, core_acc_pend, core_acc_busy, core_acc_done;
    logic bus_grant_n, bus_hung_n, bus_drv_en, core_halt;
    int   total = 0;
    int   bad   = 0;

    always #2 clk = ~clk;

    bus_grant_arb uut (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .go_mode_en(go_mode_en),
        .core_acc_pend(core_acc_pend), .core_acc_busy(core_acc_busy),
        .core_acc_done(core_acc_done), .bus_grant_n(bus_grant_n),
        .bus_hung_n(bus_hung_n), .bus_drv_en(bus_drv_en), .core_halt(core_halt)
    );

    typedef struct packed {
        logic       req_n;
        logic       go;
        logic       pend;
        logic       busy;
        logic       done;
        logic [7:0] cyc;
        logic       e_grant_n;
        logic       e_halt;
        logic       e_hung_n;
        logic [7:0] tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd9},  // R9 idle
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd4,1'b0,1'b1,1'b1,8'd3},  // R3 grant halts
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'd2,1'b0,1'b1,1'b0,8'd8},  // R8 hung
        '{1'b1,1'b0,1'b1,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd7},  // R7 release
        '{1'b1,1'b1,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd7},  // R7 idle
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'd4,1'b0,1'b0,1'b1,8'd4},  // R4 runs
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'd2,1'b0,1'b1,1'b0,8'd4},  // R4 stops on access
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd7},  // R7
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd6,1'b1,1'b0,1'b1,8'd5},  // R5 deferred
        '{1'b0,1'b0,1'b0,1'b0,1'b0,8'd2,1'b0,1'b1,1'b1,8'd5},  // R5 access over
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd7},  // R7
        '{1'b0,1'b0,1'b0,1'b1,1'b1,8'd4,1'b0,1'b1,1'b1,8'd6},  // R6 between accesses
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'd3,1'b0,1'b1,1'b1,8'd10}, // R10 busy ignored
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0,1'b1,8'd7}   // R7
    };

    task automatic chk(input string what, input int tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic outs(input int tag, input logic g_n, input logic h, input logic hu_n);
        chk("bus_grant_n", tag, bus_grant_n, g_n);
        chk("core_halt",   tag, core_halt,   h);
        chk("bus_hung_n",  tag, bus_hung_n,  hu_n);
        chk("bus_drv_en (R2)", 2, bus_drv_en, g_n);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic rq, input logic go, input logic pd,
                         input logic bz, input logic dn);
        bus_req_n = rq; go_mode_en = go; core_acc_pend = pd;
        core_acc_busy = bz; core_acc_done = dn;
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(5);
        outs(9, 1'b1, 1'b0, 1'b1);                 // R9 reset state, no request
        // R9: request honoured during reset, access inputs ignored
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        step(4);
        outs(9, 1'b0, 1'b0, 1'b1);                 // R9 granted in reset
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4);
        outs(9, 1'b1, 1'b0, 1'b1);                 // R9 released in reset
        rst_n = 1'b1;
        step(2);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].req_n, VECS[i].go, VECS[i].pend, VECS[i].busy, VECS[i].done);
            step(int'(VECS[i].cyc));
            outs(int'(VECS[i].tag), VECS[i].e_grant_n, VECS[i].e_halt, VECS[i].e_hung_n);
        end

        // R1 exact latency: grant at third edge
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(2);
        chk("R1 grant before 3rd edge", 1, bus_grant_n, 1'b1);
        step(1);
        chk("R1 grant at 3rd edge", 1, bus_grant_n, 1'b0);
        chk("R3 halt with grant", 3, core_halt, 1'b1);
        chk("R2 drivers off", 2, bus_drv_en, 1'b0);
        // R7 exact latency
        core_acc_pend = 1'b1;
        step(1);
        chk("R8 hung one edge after pend", 8, bus_hung_n, 1'b0);
        bus_req_n = 1'b1;
        step(2);
        chk("R7 still granted at 2nd edge", 7, bus_grant_n, 1'b0);
        step(1);
        outs(7, 1'b1, 1'b0, 1'b1);                 // R7 all released together
        core_acc_pend = 1'b0;
        step(2);

        // R5 exact: grant at edge that samples done
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(5);
        chk("R5 held off while busy", 5, bus_grant_n, 1'b1);
        core_acc_done = 1'b1;
        step(1);
        chk("R5 grant after completion", 5, bus_grant_n, 1'b0);
        core_acc_done = 1'b0;
        step(2);
        chk("R10 busy with no done keeps grant", 10, bus_grant_n, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4);

        // R4 exact: halt one edge after pend in run-on mode
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(5);
        chk("R4 running while granted", 4, core_halt, 1'b0);
        core_acc_pend = 1'b1;
        step(1);
        chk("R4 halt one edge after pend", 4, core_halt, 1'b1);
        chk("R8 hung with pend", 8, bus_hung_n, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step(4);
        outs(7, 1'b1, 1'b0, 1'b1);                 // R7

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule